// File: doc/BRIEF.md
# Three-Voice Chord Sequencer

This block plays three musical parts at once, each on its own square-wave output pin. Every part is a list of notes held in an internal constant table. A note pairs a tone frequency in hertz with a length in milliseconds. A five-line one-hot selector picks the song. The block then walks the three lists in parallel, each with its own pointer and its own remaining-time counter.

Time is cut into fixed slices of 25 ms, measured by a slice counter that runs from the system clock. A part's frequency is latched for a whole slice, so the outputs form a series of three-note chords. Within a slice, each part's tone generator counts system clock cycles and toggles its pin every half period. A frequency of zero is a rest and keeps the pin low. A reserved duration value marks the end of a part's list, and the part stays on that entry until a new selection arrives.

Each part is controlled by a three-state machine:
- IDLE: no song is selected. The part is silent.
- PLAY: the part is inside its note list.
- HOLD: the part has reached its end marker.

The transitions are:
- SELECT_START (IDLE to PLAY or HOLD): taken when the selector changes to a valid song.
- SLICE_ADVANCE (PLAY to PLAY): taken at a slice end when the current note is used up.
- REACH_END (PLAY to HOLD): taken when the next entry is the end marker.
- RESELECT (from any state): taken on any selector change. It goes to IDLE when no line is active.

Top module: `chord_sequencer`

## Requirements
- R1: Each of the three parts drives `tone_o[p]` as a square wave with a 50% duty cycle. Each level lasts exactly floor(CLK_HZ / (2*f)) clock cycles, where f is the frequency of the part's current entry.
- R2: A slice lasts SLICE_CYCLES clock cycles. The slice grid restarts on the clock edge where a selector change is first seen, so slice k begins k*SLICE_CYCLES edges later.
- R3: A part's frequency changes only at a slice boundary or on a selector change. Within a slice, every complete high pulse of that part has the same width.
- R4: An entry with frequency 0 is a rest. From the cycle after it takes effect until the slice ends, its output stays low.
- R5: At each slice end, a part's remaining duration drops by 25 ms. When the remaining duration is 25 or less at that boundary, the part moves to its next entry instead. As a result, a zero-duration entry lasts exactly one slice.
- R6: `sel_i[k]` selects song k, for k from 0 to 4. If several lines are high, the lowest index wins. If no line is high, all three parts are silent.
- R7: Any change on `sel_i` returns all three pointers to entry 0 of the newly decoded song. This holds even when the same song is decoded again.
- R8: An entry with duration 0xFFFF is the end marker. It is never decremented. The part keeps playing that entry's frequency until the next selector change, and a frequency of 0 means silence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of CLK_HZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_i | input | 5 | One-hot song selector |
| tone_o | output | 3 | Square-wave output, one bit per part |

## Verification
The assertions check the following on every cycle:
- The slice counter stays in range and wraps to zero after each tick.
- Part frequencies stay unchanged between boundaries.
- A part whose frequency is zero is low on the next cycle.
- A part in HOLD keeps its pointer.
- No selection means all frequencies are zero.

Only the bench's scenarios can show the following:
- The actual note order of each song.
- The duration countdown, including the zero-length entry and the move onto the end marker.
- Pulse widths matching the half-period formula.
- Exact slice-boundary timing.
- The lowest-index rule for several select lines.
- The restart taken when the selector changes but decodes to the same song.

// File: rtl/chord_seq_pkg.sv
package chord_seq_pkg;

    localparam int NSONG    = 5;
    localparam int NPART    = 3;
    localparam int DEPTH    = 8;
    localparam int SLICE_MS = 25;
    localparam int SIW      = $clog2(NSONG);
    localparam int PW       = $clog2(DEPTH);
    localparam logic [15:0] END_DUR = 16'hFFFF;

    typedef struct packed {
        logic [15:0] freq;
        logic [15:0] dur;
    } note_t;

    typedef enum logic [1:0] {V_IDLE, V_PLAY, V_HOLD} vstate_e;

    // Note table: song s, part p, entry i. Evaluated only at elaboration.
    function automatic note_t song_note(input int s, input int p, input int i);
        note_t r;
        int    n;
        n = 3 + ((s + p) % 4);
        if (i < n) begin
            r.freq = 16'(200 + 100 * ((3 * s + 5 * p + 7 * i) % 16));
            if ((i + p + s) % 5 == 4) r.freq = 16'd0;
            r.dur = 16'(SLICE_MS * (1 + ((s + 2 * p + i) % 3)));
            if (s == 1 && p == 0 && i == 1) r.dur = 16'd0;
        end else begin
            r.freq = (s == 0 && p == 2 && i == n) ? 16'd300 : 16'd0;
            r.dur  = END_DUR;
        end
        return r;
    endfunction

endpackage

// File: rtl/seq_slice_timer.sv
module seq_slice_timer #(
    parameter int SLICE_CYCLES = 1000,
    parameter int SW = $clog2(SLICE_CYCLES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic          tick,
    output logic [SW-1:0] cnt
);
    assign tick = (cnt == SW'(SLICE_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (tick)    cnt <= '0;
        else              cnt <= cnt + SW'(1);
    end
endmodule

// File: rtl/seq_voice.sv
module seq_voice
    import chord_seq_pkg::*;
#(
    parameter int PART   = 0,
    parameter int CLK_HZ = 50_000_000,
    parameter int HW     = $clog2(CLK_HZ / 2 + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           song_valid,
    input  logic [SIW-1:0] song_idx,
    input  logic           tick,
    output logic [15:0]    freq_o,
    output logic [HW-1:0]  half_o,
    output logic [PW-1:0]  ptr_o,
    output logic           hold_o
);
    logic [15:0]   rom_f [NSONG][DEPTH];
    logic [15:0]   rom_d [NSONG][DEPTH];
    logic [HW-1:0] rom_h [NSONG][DEPTH];

    for (genvar s = 0; s < NSONG; s++) begin : g_song
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            localparam note_t NT = song_note(s, PART, i);
            assign rom_f[s][i] = NT.freq;
            assign rom_d[s][i] = NT.dur;
            assign rom_h[s][i] = (NT.freq == 16'd0) ? '0
                               : HW'(CLK_HZ / (2 * int'(NT.freq)));
        end
    end

    vstate_e        state, state_n, start_st;
    logic [PW-1:0]  ptr, ptr_nxt;
    logic [15:0]    rem, first_dur, nxt_dur;
    logic [SIW-1:0] song_q;
    logic           last_slice;

    assign ptr_nxt    = ptr + PW'(1);
    assign first_dur  = rom_d[song_idx][0];
    assign nxt_dur    = rom_d[song_q][ptr_nxt];
    assign last_slice = (rem <= 16'(SLICE_MS));
    assign start_st   = !song_valid ? V_IDLE
                      : (first_dur == END_DUR) ? V_HOLD : V_PLAY;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= V_IDLE;
        else        state <= state_n;
    end

    // Transitions: SELECT_START, SLICE_ADVANCE, REACH_END, RESELECT
    always_comb begin
        state_n = state;
        unique case (state)
            V_IDLE: if (restart) state_n = start_st;
            V_PLAY: begin
                if (restart)
                    state_n = start_st;
                else if (tick && last_slice)
                    state_n = (nxt_dur == END_DUR) ? V_HOLD : V_PLAY;
            end
            V_HOLD: if (restart) state_n = start_st;
            default: state_n = V_IDLE;
        endcase
    end

    // Pointer and remaining-time datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr    <= '0;
            rem    <= '0;
            song_q <= '0;
        end else if (restart) begin
            ptr    <= '0;
            song_q <= song_idx;
            rem    <= first_dur;
        end else if (tick && state == V_PLAY) begin
            if (last_slice) begin
                ptr <= ptr_nxt;
                rem <= nxt_dur;
            end else begin
                rem <= rem - 16'(SLICE_MS);
            end
        end
    end

    // Outputs
    always_comb begin
        freq_o = (state == V_IDLE) ? 16'd0 : rom_f[song_q][ptr];
        half_o = (state == V_IDLE) ? '0    : rom_h[song_q][ptr];
        ptr_o  = ptr;
        hold_o = (state == V_HOLD);
    end
endmodule

// File: rtl/seq_tone.sv
module seq_tone #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   freq_i,
    input  logic [HW-1:0] half_i,
    output logic          tone_o
);
    logic [15:0]   prev_f;
    logic [HW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_f <= '0;
            cnt    <= '0;
            tone_o <= 1'b0;
        end else if (freq_i != prev_f) begin
            prev_f <= freq_i;
            cnt    <= '0;
            tone_o <= 1'b0;
        end else if (freq_i == 16'd0) begin
            cnt    <= '0;
            tone_o <= 1'b0;
        end else if (cnt == half_i - HW'(1)) begin
            cnt    <= '0;
            tone_o <= ~tone_o;
        end else begin
            cnt <= cnt + HW'(1);
        end
    end
endmodule

// File: rtl/chord_sequencer.sv
module chord_sequencer
    import chord_seq_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int SLICE_CYCLES = CLK_HZ / 1000 * SLICE_MS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSONG-1:0] sel_i,
    output logic [NPART-1:0] tone_o
);
    localparam int HW = $clog2(CLK_HZ / 2 + 1);
    localparam int SW = $clog2(SLICE_CYCLES);

    logic [NSONG-1:0] sel_q;
    logic             restart, tick, song_valid;
    logic [SIW-1:0]   song_idx;
    logic [SW-1:0]    slice_cnt;

    logic [NPART-1:0][15:0]   freq_all;
    logic [NPART-1:0][HW-1:0] half_all;
    logic [NPART-1:0][PW-1:0] ptr_all;
    logic [NPART-1:0]         hold_all;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_i;
    end
    assign restart = (sel_i != sel_q);

    // Lowest active line wins
    always_comb begin
        song_idx   = '0;
        song_valid = 1'b0;
        for (int k = NSONG - 1; k >= 0; k--) begin
            if (sel_i[k]) begin
                song_idx   = SIW'(k);
                song_valid = 1'b1;
            end
        end
    end

    seq_slice_timer #(.SLICE_CYCLES(SLICE_CYCLES), .SW(SW)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick), .cnt(slice_cnt)
    );

    for (genvar p = 0; p < NPART; p++) begin : g_part
        seq_voice #(.PART(p), .CLK_HZ(CLK_HZ), .HW(HW)) u_voice (
            .clk(clk), .rst_n(rst_n), .restart(restart),
            .song_valid(song_valid), .song_idx(song_idx), .tick(tick),
            .freq_o(freq_all[p]), .half_o(half_all[p]),
            .ptr_o(ptr_all[p]), .hold_o(hold_all[p])
        );
        seq_tone #(.HW(HW)) u_tone (
            .clk(clk), .rst_n(rst_n), .freq_i(freq_all[p]),
            .half_i(half_all[p]), .tone_o(tone_o[p])
        );
    end
endmodule

// File: rtl/chord_sequencer_chk.sv
module chord_sequencer_chk #(
    parameter int NSONG        = 5,
    parameter int NPART        = 3,
    parameter int SLICE_CYCLES = 1000,
    parameter int SW           = 10,
    parameter int PW           = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     restart,
    input logic                     tick,
    input logic [SW-1:0]            slice_cnt,
    input logic [NSONG-1:0]         sel_q,
    input logic [NPART-1:0][15:0]   freq_all,
    input logic [NPART-1:0][PW-1:0] ptr_all,
    input logic [NPART-1:0]         hold_all,
    input logic [NPART-1:0]         tone_o
);
    a_r2_slice_range: assert property (@(posedge clk) disable iff (!rst_n)
        slice_cnt < SW'(SLICE_CYCLES));

    a_r2_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> slice_cnt == '0);

    a_r3_freq_held_in_slice: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick || restart) |=> $stable(freq_all));

    a_r6_unselected_silent: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q == '0 |-> freq_all == '0);

    for (genvar p = 0; p < NPART; p++) begin : g_chk
        a_r4_rest_low: assert property (@(posedge clk) disable iff (!rst_n)
            freq_all[p] == 16'd0 |=> !tone_o[p]);

        a_r8_hold_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_all[p] && !restart) |=> (hold_all[p] && $stable(ptr_all[p])));
    end
endmodule

bind chord_sequencer chord_sequencer_chk #(
    .NSONG(NSONG), .NPART(NPART), .SLICE_CYCLES(SLICE_CYCLES), .SW(SW), .PW(PW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .slice_cnt(slice_cnt), .sel_q(sel_q), .freq_all(freq_all),
    .ptr_all(ptr_all), .hold_all(hold_all), .tone_o(tone_o)
);

// File: tb/chord_sequencer_test.sv
`timescale 1ns/1ps
module chord_sequencer_test;
    import chord_seq_pkg::*;

    localparam int CLK_HZ = 20_000;
    localparam int S      = 500;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSONG-1:0] sel_i = '0;
    logic [NPART-1:0] tone_o;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit mon_busy = 1'b0;

    typedef struct {
        int    start;
        int    f[NPART];
        string tag[NPART];
    } item_t;
    item_t q[$];

    chord_sequencer #(.CLK_HZ(CLK_HZ), .SLICE_CYCLES(S)) uut (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .tone_o(tone_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int half_of(input int f);
        return CLK_HZ / (2 * f);
    endfunction

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Driver: called at a negedge, changes the selector, pushes expected slices
    task automatic start_song(input logic [NSONG-1:0] sel, input int nsl,
                              input string tg, output int e0);
        int    s, ptr[NPART], rem[NPART];
        bit    valid;
        item_t it;
        note_t n;
        valid = 1'b0;
        s = 0;
        for (int k = NSONG - 1; k >= 0; k--) if (sel[k]) begin s = k; valid = 1'b1; end
        sel_i = sel;
        e0 = cyc + 1;
        for (int p = 0; p < NPART; p++) begin
            ptr[p] = 0;
            n = song_note(s, p, 0);
            rem[p] = int'(n.dur);
        end
        for (int k = 0; k < nsl; k++) begin
            it.start = e0 + k * S;
            for (int p = 0; p < NPART; p++) begin
                n = song_note(s, p, ptr[p]);
                if (!valid) begin
                    it.f[p] = 0; it.tag[p] = "R6";
                end else begin
                    it.f[p] = int'(n.freq);
                    if (rem[p] == int'(END_DUR)) it.tag[p] = "R8";
                    else if (it.f[p] == 0)       it.tag[p] = "R4";
                    else                          it.tag[p] = tg;
                end
                if (rem[p] != int'(END_DUR)) begin
                    if (rem[p] <= SLICE_MS) begin
                        ptr[p]++;
                        n = song_note(s, p, ptr[p]);
                        rem[p] = int'(n.dur);
                    end else begin
                        rem[p] -= SLICE_MS;
                    end
                end
            end
            q.push_back(it);
        end
    endtask

    function automatic int song_slices(input int s);
        int tot, sl;
        note_t n;
        tot = 0;
        for (int p = 0; p < NPART; p++) begin
            sl = 0;
            for (int i = 0; i < DEPTH; i++) begin
                n = song_note(s, p, i);
                if (n.dur == END_DUR) break;
                sl += (n.dur == 16'd0) ? 1 : int'(n.dur) / SLICE_MS;
            end
            if (sl > tot) tot = sl;
        end
        return tot;
    endfunction

    // Monitor: measures pulse widths per slice and compares to the queue
    initial begin
        item_t it;
        bit    prev[NPART], seen[NPART];
        int    run[NPART], first[NPART], bad[NPART];
        bit    v;
        forever begin
            wait (q.size() > 0);
            it = q.pop_front();
            mon_busy = 1'b1;
            wait_cyc(it.start);
            for (int p = 0; p < NPART; p++) begin
                prev[p] = 0; seen[p] = 0; run[p] = 0; first[p] = -1; bad[p] = 0;
            end
            for (int j = 0; j < S; j++) begin
                if (j >= 2) begin
                    for (int p = 0; p < NPART; p++) begin
                        v = tone_o[p];
                        if (j > 2) begin
                            if (!prev[p] && v) run[p] = 1;
                            else if (prev[p] && v && run[p] > 0) run[p]++;
                            else if (prev[p] && !v && run[p] > 0) begin
                                if (first[p] < 0) first[p] = run[p];
                                else if (run[p] != first[p]) bad[p]++;
                                run[p] = 0;
                            end
                        end
                        if (v) seen[p] = 1;
                        prev[p] = v;
                    end
                end
                if (j < S - 1) @(negedge clk);
            end
            for (int p = 0; p < NPART; p++) begin
                if (it.f[p] == 0) begin
                    check(!seen[p], it.tag[p], int'(seen[p]), 0);
                end else begin
                    check(first[p] == half_of(it.f[p]), it.tag[p], first[p], half_of(it.f[p]));
                    check(bad[p] == 0, "R3", bad[p], 0);
                end
            end
            mon_busy = 1'b0;
        end
    end

    // Watchdog
    initial begin
        repeat (190_000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int    e0, h1;
        note_t n1;
        repeat (3) @(negedge clk);
        check(tone_o == '0, "R6", int'(tone_o), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(tone_o == '0, "R6", int'(tone_o), 0);

        // Song 0 with slice-boundary timing (part 0: entry 0 lasts one slice)
        start_song(5'b00001, song_slices(0) + 3, "R1", e0);
        n1 = song_note(0, 0, 1);
        h1 = half_of(int'(n1.freq));
        wait_cyc(e0 + S + h1);
        check(tone_o[0] == 1'b0, "R2", int'(tone_o[0]), 0);
        @(negedge clk);
        check(tone_o[0] == 1'b1, "R2", int'(tone_o[0]), 1);
        wait_cyc(e0 + (song_slices(0) + 3) * S - 1);

        // Song 1 contains a zero-duration entry
        start_song(5'b00010, song_slices(1) + 2, "R5", e0);
        wait_cyc(e0 + (song_slices(1) + 2) * S - 1);

        // Song 2 interrupted after 4 slices by song 3
        start_song(5'b00100, 4, "R1", e0);
        wait_cyc(e0 + 4 * S - 1);
        start_song(5'b01000, song_slices(3) + 2, "R7", e0);
        wait_cyc(e0 + (song_slices(3) + 2) * S - 1);

        start_song(5'b10000, song_slices(4) + 2, "R1", e0);
        wait_cyc(e0 + (song_slices(4) + 2) * S - 1);

        // No line active
        start_song(5'b00000, 3, "R6", e0);
        wait_cyc(e0 + 3 * S - 1);

        // Two lines active: lowest (song 2) wins
        start_song(5'b10100, 5, "R6", e0);
        wait_cyc(e0 + 5 * S - 1);

        // Selector changes but decodes to the same song: restart from entry 0
        start_song(5'b00100, song_slices(2) + 2, "R7", e0);
        wait_cyc(e0 + (song_slices(2) + 2) * S - 1);

        wait (q.size() == 0 && !mon_busy);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule